// File: doc/BRIEF.md
# If-Then Block Conditional Execution Tracker

This block sits in the front end of a binary translator that runs a foreign instruction set on a host core. The foreign set has an "if-then" prefix instruction that makes the next one to four instructions conditional. The block holds an 8-bit state register for the open block. For every instruction that reaches the translator it decides, in the same cycle, whether the instruction goes on to translation or is dropped. Squashed instructions never reach the execute stage, so no pipeline cycles are spent on them.

The prefix instruction supplies a 4-bit first condition and a 4-bit mask. Mask bits give the then/else sense of each later slot, and the lowest set mask bit marks where the block ends. The block tests each slot's condition against the current N, Z, C and V flags. It uses the same 4-bit condition code that the host branch unit uses. A cycle with the valid strobe low changes nothing.

Top module: `it_tracker`

## Requirements
- R1: After reset the state is empty: `in_block` is 0, and both `exec_go` and `exec_skip` are 0 while `instr_valid` is 0.
- R2: When no block is open, every valid instruction gives `exec_go`=1 and `exec_skip`=0, whatever the flags and the condition and mask inputs.
- R3: A valid prefix instruction (`is_it`=1) seen outside a block with a nonzero mask is itself executed (`exec_go`=1). It loads the state as {condition, mask}, and `in_block` reads 1 from the next cycle.
- R4: The block covers 1, 2, 3 or 4 instructions when the lowest set mask bit is bit 3, 2, 1 or 0. `in_block` falls in the cycle after the last of them is consumed.
- R5: Inside a block each instruction's condition code is tested on the flags: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V). On a pass the output is `exec_go`, otherwise `exec_skip`.
- R6: The first instruction of a block uses the prefix condition as given. Instruction k (k=2..4) keeps condition bits [3:1] and takes its bit 0 from mask bit 5-k.
- R7: A cycle with `instr_valid`=0 drives neither `exec_go` nor `exec_skip` and does not advance or change the state.
- R8: A prefix instruction with mask 0000 is executed but opens no block: `in_block` stays 0.
- R9: A prefix instruction that arrives inside an open block counts as an ordinary slot of that block. It is evaluated with the current slot's condition and does not reload the state.
- R10: For every valid instruction exactly one of `exec_go` and `exec_skip` is 1.
- R11: Condition codes 14 and 15 always pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| is_it | input | 1 | The presented instruction is the if-then prefix |
| it_cond | input | 4 | First condition field of the prefix |
| it_mask | input | 4 | Then/else mask field of the prefix |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| exec_go | output | 1 | Presented instruction is to be translated |
| exec_skip | output | 1 | Presented instruction is squashed |
| in_block | output | 1 | An if-then block is open |

## Verification
A corrupt state register shows at the ports within one consumed instruction. A wrong upper condition field or then/else bit turns a `exec_go` into `exec_skip`, or the reverse, on the next slot whose flags tell the two apart. A wrong mask shift ends the block early or late, and `in_block` then disagrees with the slot count in the cycle after the affected slot. A stall that moves the state is seen on the first valid instruction after the stall, because that instruction is then tested against the wrong slot's condition.

// File: rtl/it_pkg.sv
package it_pkg;
  localparam int COND_W  = 4;
  localparam int MASK_W  = 4;
  localparam int STATE_W = COND_W + MASK_W;
  localparam int HI_LSB  = MASK_W + 1;
  localparam logic [COND_W-1:0] COND_ALWAYS = {COND_W{1'b1}} - 1'b1;

  typedef logic [STATE_W-1:0] it_state_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic cond_holds(logic [COND_W-1:0] cond, nzcv_t f);
    logic base;
    unique case (cond[COND_W-1:1])
      3'd0:    base = f.z;
      3'd1:    base = f.c;
      3'd2:    base = f.n;
      3'd3:    base = f.v;
      3'd4:    base = f.c & ~f.z;
      3'd5:    base = (f.n == f.v);
      3'd6:    base = ~f.z & (f.n == f.v);
      default: base = 1'b1;
    endcase
    if (cond[COND_W-1:1] == 3'b111) return 1'b1;
    return base ^ cond[0];
  endfunction

  function automatic it_state_t state_step(it_state_t s);
    it_state_t nxt;
    nxt = {s[STATE_W-1:HI_LSB], s[MASK_W-1:0], 1'b0};
    if (nxt[MASK_W-1:0] == '0) nxt = '0;
    return nxt;
  endfunction

  function automatic logic state_open(it_state_t s);
    return |s[MASK_W-1:0];
  endfunction
endpackage

// File: rtl/it_cond_eval.sv
module it_cond_eval
  import it_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  nzcv_t             flags,
  output logic              pass
);
  always_comb pass = cond_holds(cond, flags);
endmodule

// File: rtl/it_state_reg.sv
module it_state_reg
  import it_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_en,
  input  it_state_t load_val,
  input  logic      step_en,
  output it_state_t state_q
);
  it_state_t state_d;

  always_comb begin
    state_d = state_q;
    if (load_en)      state_d = load_val;
    else if (step_en) state_d = state_step(state_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/it_issue_ctrl.sv
module it_issue_ctrl
  import it_pkg::*;
(
  input  logic              instr_valid,
  input  logic              is_it,
  input  logic [COND_W-1:0] it_cond,
  input  logic [MASK_W-1:0] it_mask,
  input  it_state_t         state_q,
  output logic              open_q,
  output logic              load_en,
  output it_state_t         load_val,
  output logic              step_en,
  output logic [COND_W-1:0] slot_cond
);
  always_comb begin
    open_q    = state_open(state_q);
    load_val  = {it_cond, it_mask};
    load_en   = instr_valid & is_it & ~open_q & (|it_mask);
    step_en   = instr_valid & open_q;
    slot_cond = open_q ? state_q[STATE_W-1:MASK_W] : COND_ALWAYS;
  end
endmodule

// File: rtl/it_tracker.sv
module it_tracker
  import it_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic              is_it,
  input  logic [COND_W-1:0] it_cond,
  input  logic [MASK_W-1:0] it_mask,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  output logic              exec_go,
  output logic              exec_skip,
  output logic              in_block
);
  it_state_t         state_q;
  it_state_t         load_val;
  logic              open_q;
  logic              load_en;
  logic              step_en;
  logic [COND_W-1:0] slot_cond;
  logic              slot_pass;
  nzcv_t             flags;

  assign flags = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

  it_issue_ctrl u_ctrl (
    .instr_valid (instr_valid),
    .is_it       (is_it),
    .it_cond     (it_cond),
    .it_mask     (it_mask),
    .state_q     (state_q),
    .open_q      (open_q),
    .load_en     (load_en),
    .load_val    (load_val),
    .step_en     (step_en),
    .slot_cond   (slot_cond)
  );

  it_state_reg u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_val (load_val),
    .step_en  (step_en),
    .state_q  (state_q)
  );

  it_cond_eval u_eval (
    .cond  (slot_cond),
    .flags (flags),
    .pass  (slot_pass)
  );

  assign exec_go   = instr_valid & slot_pass;
  assign exec_skip = instr_valid & ~slot_pass;
  assign in_block  = open_q;
endmodule

// File: rtl/it_tracker_chk.sv
module it_tracker_chk
  import it_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              is_it,
  input logic [COND_W-1:0] it_cond,
  input logic [MASK_W-1:0] it_mask,
  input logic              exec_go,
  input logic              exec_skip,
  input logic              in_block,
  input it_state_t         state_q
);
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> ($countones({exec_go, exec_skip}) == 1));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (!exec_go && !exec_skip));

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(state_q));

  a_r2_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !in_block) |-> exec_go);

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && is_it && !in_block && (it_mask != '0))
      |=> (in_block && state_q == {$past(it_cond), $past(it_mask)}));

  a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && is_it && !in_block && (it_mask == '0)) |=> !in_block);

  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && in_block)
      |=> (state_q[STATE_W-1:HI_LSB] == $past(state_q[STATE_W-1:HI_LSB]) || !in_block));

  a_r4_block_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && in_block)
      |=> ($countones(state_q[MASK_W-1:0]) <= $countones($past(state_q[MASK_W-1:0]))));
endmodule

bind it_tracker it_tracker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .is_it       (is_it),
  .it_cond     (it_cond),
  .it_mask     (it_mask),
  .exec_go     (exec_go),
  .exec_skip   (exec_skip),
  .in_block    (in_block),
  .state_q     (state_q)
);

// File: tb/it_tracker_tb.sv
module it_tracker_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic is_it = 1'b0;
  logic [3:0] it_cond = '0;
  logic [3:0] it_mask = '0;
  logic flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
  logic exec_go, exec_skip, in_block;

  int n_checks = 0;
  int n_errors = 0;

  int       m_len = 0;
  int       m_idx = 0;
  bit [3:0] m_fc  = '0;
  bit [3:0] m_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  it_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .is_it(is_it),
    .it_cond(it_cond), .it_mask(it_mask), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .exec_go(exec_go), .exec_skip(exec_skip),
    .in_block(in_block)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // flags given as {N,Z,C,V}
  function automatic bit ref_pass(bit [3:0] code, bit [3:0] f);
    bit n, z, c, v;
    {n, z, c, v} = f;
    case (code)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic int ref_len_of(bit [3:0] m);
    for (int p = 0; p < 4; p++) if (m[p]) return 4 - p;
    return 0;
  endfunction

  task automatic issue(bit v, bit it, bit [3:0] c, bit [3:0] m, bit [3:0] f, string req);
    bit exp_go, exp_skip;
    bit [3:0] slot;
    @(negedge clk);
    instr_valid = v; is_it = it; it_cond = c; it_mask = m;
    {flag_n, flag_z, flag_c, flag_v} = f;
    #1;
    if (!v) begin
      exp_go = 0; exp_skip = 0;
    end else if (m_len == 0) begin
      exp_go = 1; exp_skip = 0;
    end else begin
      slot = {m_fc[3:1], (m_idx == 0) ? m_fc[0] : m_mask[4 - m_idx]};
      exp_go = ref_pass(slot, f);
      exp_skip = !exp_go;
    end
    check(exec_go == exp_go, req, "exec_go", exec_go, exp_go);
    check(exec_skip == exp_skip, req, "exec_skip", exec_skip, exp_skip);
    check(!(exec_go && exec_skip) && (exec_go || exec_skip) == v, "R10", "one outcome",
          int'(exec_go) + int'(exec_skip), int'(v));
    if (v) begin
      if (m_len != 0) begin
        m_idx++;
        if (m_idx == m_len) begin m_len = 0; m_idx = 0; end
      end else if (it && m != 0) begin
        m_fc = c; m_mask = m; m_len = ref_len_of(m); m_idx = 0;
      end
    end
    @(posedge clk); #1;
    check(in_block == (m_len != 0), req, "in_block", in_block, int'(m_len != 0));
    instr_valid = 0; is_it = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(in_block == 0, "R1", "in_block in reset", in_block, 0);
    check(!exec_go && !exec_skip, "R1", "outputs idle", int'(exec_go | exec_skip), 0);
    rst_n = 1;
    @(posedge clk); #1;
    check(in_block == 0, "R1", "in_block after reset", in_block, 0);
  endtask

  task automatic t_plain();
    for (int i = 0; i < 16; i++)
      issue(1, 0, 4'(i), 4'(15 - i), 4'(i * 5), "R2");
  endtask

  task automatic t_lengths();
    bit [3:0] masks[7] = '{4'b1000, 4'b0100, 4'b1100, 4'b0010, 4'b1010, 4'b0001, 4'b1111};
    foreach (masks[k]) begin
      issue(1, 1, 4'd14, masks[k], 4'd0, "R3");
      for (int j = 0; j < 5; j++) issue(1, 0, 4'd0, 4'd0, 4'(j), "R4");
    end
  endtask

  task automatic t_then_else();
    bit [3:0] masks[4] = '{4'b0001, 4'b1001, 4'b0101, 4'b1011};
    foreach (masks[k]) begin
      issue(1, 1, 4'd0, masks[k], 4'd0, "R3");
      for (int j = 0; j < 4; j++) issue(1, 0, 4'd0, 4'd0, 4'b0100, "R6");
      issue(1, 1, 4'd1, masks[k], 4'd0, "R3");
      for (int j = 0; j < 4; j++) issue(1, 0, 4'd0, 4'd0, 4'b0000, "R6");
    end
  endtask

  task automatic t_cond_sweep();
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        issue(1, 1, 4'(c), 4'b1000, 4'(f), "R3");
        issue(1, 0, 4'd0, 4'd0, 4'(f), (c >= 14) ? "R11" : "R5");
      end
  endtask

  task automatic t_stall();
    issue(1, 1, 4'd2, 4'b0110, 4'd0, "R3");
    issue(0, 0, 4'd0, 4'd0, 4'b0010, "R7");
    issue(0, 1, 4'd5, 4'b1000, 4'b0010, "R7");
    issue(1, 0, 4'd0, 4'd0, 4'b0010, "R7");
    issue(0, 0, 4'd0, 4'd0, 4'd0, "R7");
    issue(1, 0, 4'd0, 4'd0, 4'b0000, "R7");
    issue(1, 0, 4'd0, 4'd0, 4'b0010, "R7");
  endtask

  task automatic t_empty_mask();
    issue(1, 1, 4'd0, 4'b0000, 4'b0000, "R8");
    issue(1, 0, 4'd0, 4'd0, 4'b0000, "R8");
  endtask

  task automatic t_nested();
    issue(1, 1, 4'd4, 4'b0100, 4'b0000, "R3");
    issue(1, 1, 4'd14, 4'b0001, 4'b1000, "R9");
    issue(1, 1, 4'd14, 4'b0001, 4'b1000, "R9");
    issue(1, 0, 4'd0, 4'd0, 4'b0000, "R9");
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 300; i++)
      issue(($urandom % 5) != 0, ($urandom % 4) == 0, 4'($urandom), 4'($urandom),
            4'($urandom), "R5");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_plain();
    t_lengths();
    t_then_else();
    t_cond_sweep();
    t_stall();
    t_empty_mask();
    t_nested();
    t_mixed();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule